// File: doc/BRIEF.md
# Dual Signed Multiply-Subtract Accumulator

This block is a single registered datapath stage. Each of its two operands holds a pair of signed halfwords. It multiplies the halfwords in pairs and subtracts the upper-pair product from the lower-pair product. When accumulation is enabled, it adds a signed accumulate value to that difference. The low operand-width bits of the full-precision sum are registered as the result.

A swap control rotates the second operand by one halfword before the multiplies, so the halfwords pair crosswise. A sticky overflow flag records each time an accumulate result does not fit the output width. The flag stays set until a dedicated clear input or a reset lowers it.

The stage has no handshake. When the enable input is high, one clock edge captures the new result and the flag update. When enable is low, both hold. The latency is one cycle and does not depend on the operand values. The halfword width is a parameter and defaults to 16, which gives 32-bit operands.

Top module: `dsma_top`

## Requirements
- R1: With swap low, the result is (signed low half of A × signed low half of B) minus (signed high half of A × signed high half of B), plus the addend, truncated to the low 2·HALF_W bits. The low half is bits [HALF_W-1:0].
- R2: With swap high, B is rotated by HALF_W bits before the split, so the low half of A multiplies the high half of B, and the high half of A multiplies the low half of B.
- R3: With accumulation enabled, the sign-extended accumulate value is added to the product difference at full precision. The output is the low 2·HALF_W bits of that sum.
- R4: With accumulation disabled, the result is the product difference alone. Such an operation never sets the overflow flag.
- R5: The flag becomes 1 after an enabled operation whose full-precision sum differs from the sign extension of its own low 2·HALF_W bits. Once set, the flag stays 1 until it is cleared.
- R6: A high flag-clear input lowers the flag at the next edge, whether or not enable is high. If an overflowing operation is captured in the same cycle, the flag is 1.
- R7: While enable is low, the result holds its value and the flag cannot be set.
- R8: A synchronous active-high reset sets the result and the flag to 0.
- R9: With A = B = 0x80008000 and an accumulate value of 0x80000000 (default width, accumulation on), the result is 0x80000000 and the flag is not set.
- R10: The result and the flag always appear exactly one edge after the inputs are presented, whatever the data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture the result and the flag update at this edge |
| swapHalves | input | 1 | Rotate operand B by one halfword before the multiplies |
| accEn | input | 1 | Add the accumulate value (1) or produce the difference only (0) |
| flagClr | input | 1 | Clear the sticky overflow flag |
| opA | input | 2·HALF_W | First operand, two signed halfwords |
| opB | input | 2·HALF_W | Second operand, two signed halfwords |
| opAcc | input | 2·HALF_W | Signed accumulate value |
| result | output | 2·HALF_W | Registered result |
| satFlag | output | 1 | Sticky overflow flag |

## Verification
The bench builds two instances. The first uses HALF_W = 3, so its operands are 6 bits wide. Every pair of A and B values is swept with both swap settings. Each pair runs with accumulation off and with accumulation on at the extreme and zero addend values. Enable and clear are interleaved on fixed schedules, which drives every wrap, overflow, hold and clear-priority case. The second instance uses the default HALF_W = 16 and runs directed vectors: the most-negative corner case, overflow at both ends of the range, the same-cycle clear against overflow, and reset.

// File: rtl/dsma_pkg.sv
package dsma_pkg;

  // operand shaping chosen by the control before the arithmetic
  typedef struct packed {
    logic rotateB;
    logic addAcc;
  } dsmaOpSel_t;

  // commit strobes for the result and flag registers
  typedef struct packed {
    logic capture;
    logic flagSet;
    logic flagClr;
  } dsmaCommit_t;

endpackage

// File: rtl/dsma_halfmul.sv
module dsma_halfmul #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]          a,
  input  logic [HALF_W-1:0]          b,
  output logic signed [2*HALF_W-1:0] p
);
  // full signed product; a 2*HALF_W-bit field always holds it
  assign p = $signed(a) * $signed(b);
endmodule

// File: rtl/dsma_control.sv
module dsma_control
  import dsma_pkg::*;
(
  input  logic        en,
  input  logic        swapHalves,
  input  logic        accEn,
  input  logic        flagClr,
  input  logic        sumOvf,
  output dsmaOpSel_t  opSel,
  output dsmaCommit_t commit
);
  always_comb begin
    opSel.rotateB  = swapHalves;
    opSel.addAcc   = accEn;
    commit.capture = en;
    // only a captured operation may raise the flag
    commit.flagSet = en & sumOvf;
    commit.flagClr = flagClr;
  end
endmodule

// File: rtl/dsma_datapath.sv
module dsma_datapath
  import dsma_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic [2*HALF_W-1:0] opAcc,
  input  dsmaOpSel_t         opSel,
  input  dsmaCommit_t        commit,
  output logic               sumOvf,
  output logic [2*HALF_W-1:0] resultQ,
  output logic               flagQ
);
  localparam int OP_W   = 2 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;
  localparam int DIFF_W = PROD_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int TOP_W  = SUM_W - OP_W + 1;

  logic [OP_W-1:0]          opBSel;
  logic signed [PROD_W-1:0] prod [2];
  logic [DIFF_W-1:0]        diff;
  logic [SUM_W-1:0]         addend;
  logic [SUM_W-1:0]         sum;
  logic [TOP_W-1:0]         sumTop;

  assign opBSel = opSel.rotateB ? {opB[HALF_W-1:0], opB[OP_W-1:HALF_W]} : opB;

  // lane 0 multiplies the low halves, lane 1 the high halves
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    dsma_halfmul #(.HALF_W(HALF_W)) mul_i (
      .a(opA[lane*HALF_W +: HALF_W]),
      .b(opBSel[lane*HALF_W +: HALF_W]),
      .p(prod[lane])
    );
  end

  // the difference cannot overflow DIFF_W bits
  assign diff   = {prod[0][PROD_W-1], prod[0]} - {prod[1][PROD_W-1], prod[1]};
  assign addend = opSel.addAcc ? {{(SUM_W-OP_W){opAcc[OP_W-1]}}, opAcc} : '0;
  assign sum    = {diff[DIFF_W-1], diff} + addend;

  // the sum fits when every bit from the output sign bit upward agrees
  assign sumTop = sum[SUM_W-1:OP_W-1];
  assign sumOvf = (sumTop != '0) && (sumTop != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      flagQ   <= 1'b0;
    end else begin
      if (commit.capture) resultQ <= sum[OP_W-1:0];
      if (commit.flagSet)      flagQ <= 1'b1;
      else if (commit.flagClr) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/dsma_top.sv
module dsma_top
  import dsma_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                swapHalves,
  input  logic                accEn,
  input  logic                flagClr,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic [2*HALF_W-1:0] opAcc,
  output logic [2*HALF_W-1:0] result,
  output logic                satFlag
);
  dsmaOpSel_t  opSel;
  dsmaCommit_t commit;
  logic        sumOvf;

  dsma_control ctrl_i (
    .en(en),
    .swapHalves(swapHalves),
    .accEn(accEn),
    .flagClr(flagClr),
    .sumOvf(sumOvf),
    .opSel(opSel),
    .commit(commit)
  );

  dsma_datapath #(.HALF_W(HALF_W)) dp_i (
    .clk(clk),
    .rst(rst),
    .opA(opA),
    .opB(opB),
    .opAcc(opAcc),
    .opSel(opSel),
    .commit(commit),
    .sumOvf(sumOvf),
    .resultQ(result),
    .flagQ(satFlag)
  );
endmodule

// File: rtl/dsma_checker.sv
module dsma_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic                accEn,
  input logic                flagClr,
  input logic [2*HALF_W-1:0] result,
  input logic                satFlag
);
  // R7: a stage that is not enabled keeps its result
  assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result));

  // R5: the flag is sticky without a clear
  assert_sticky_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (satFlag && !flagClr) |=> satFlag);

  // R6: a clear with no captured operation lowers the flag
  assert_clear_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (flagClr && !en) |=> !satFlag);

  // R4 and R7: only an enabled accumulate can raise the flag
  assert_rise_needs_acc_R4: assert property (@(posedge clk) disable iff (rst)
    !(en && accEn) |=> !$rose(satFlag));

  // R6: when the clear wins, nothing was captured with accumulation
  assert_clear_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (flagClr && !(en && accEn)) |=> !satFlag);
endmodule

bind dsma_top dsma_checker #(.HALF_W(HALF_W)) chk_i (
  .clk(clk),
  .rst(rst),
  .en(en),
  .accEn(accEn),
  .flagClr(flagClr),
  .result(result),
  .satFlag(satFlag)
);

// File: tb/dsma_top_tb.sv
module dsma_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 3;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // small instance
  logic sEn = 0, sSwap = 0, sAccEn = 0, sClr = 0;
  logic [2*SW-1:0] sA = '0, sB = '0, sAcc = '0, sRes;
  logic sFlag;
  // default-width instance
  logic bEn = 0, bSwap = 0, bAccEn = 0, bClr = 0;
  logic [2*BW-1:0] bA = '0, bB = '0, bAcc = '0, bRes;
  logic bFlag;

  dsma_top #(.HALF_W(SW)) dut_i (
    .clk(clk), .rst(rst), .en(sEn), .swapHalves(sSwap), .accEn(sAccEn),
    .flagClr(sClr), .opA(sA), .opB(sB), .opAcc(sAcc), .result(sRes), .satFlag(sFlag));

  dsma_top #(.HALF_W(BW)) dut_big_i (
    .clk(clk), .rst(rst), .en(bEn), .swapHalves(bSwap), .accEn(bAccEn),
    .flagClr(bClr), .opA(bA), .opB(bB), .opAcc(bAcc), .result(bRes), .satFlag(bFlag));

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  // arithmetic reference taken from the requirements
  function automatic void refCalc(int hw, longint a, longint b, longint acc, bit sw,
                                  bit ae, output longint res, output bit ovf);
    longint m = (64'sd1 <<< hw) - 1;
    longint fm = (64'sd1 <<< (2*hw)) - 1;
    longint bb = b;
    longint sum;
    if (sw) bb = ((b & m) <<< hw) | ((b >>> hw) & m);
    sum = sx(a & m, hw) * sx(bb & m, hw) - sx((a >>> hw) & m, hw) * sx((bb >>> hw) & m, hw);
    if (ae) sum = sum + sx(acc & fm, 2*hw);
    res = sum & fm;
    ovf = (sx(res, 2*hw) != sum);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  longint sExpRes = 0, bExpRes = 0;
  bit     sExpFlag = 0, bExpFlag = 0;

  // drive at a falling edge, capture at the rising edge, check at the next falling edge
  task automatic bigStep(longint a, longint b, longint acc, bit sw, bit ae, bit e, bit c,
                         string tag);
    longint r; bit o;
    bA = a[31:0]; bB = b[31:0]; bAcc = acc[31:0];
    bSwap = sw; bAccEn = ae; bEn = e; bClr = c;
    refCalc(BW, a, b, acc, sw, ae, r, o);
    if (e) bExpRes = r;
    if (e && o) bExpFlag = 1; else if (c) bExpFlag = 0;
    @(negedge clk);
    check({tag, " result"}, longint'(bRes), bExpRes);
    check({tag, " flag R5"}, longint'(bFlag), longint'(bExpFlag));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int step = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    check("R8 small result", longint'(sRes), 0);
    check("R8 small flag", longint'(sFlag), 0);
    check("R8 big result", longint'(bRes), 0);
    check("R8 big flag", longint'(bFlag), 0);

    // R9 corner case, then directed vectors at the default width
    bigStep(64'h80008000, 64'h80008000, 64'h80000000, 0, 1, 1, 0, "R9 corner");
    check("R9 value", longint'(bRes), 64'h80000000);
    bigStep(64'h00027FFF, 64'h00037FFF, 64'h12345678, 0, 1, 1, 0, "R1 straight");
    bigStep(64'h00027FFF, 64'h00037FFF, 64'h12345678, 1, 1, 1, 0, "R2 swapped");
    bigStep(64'h7FFF8000, 64'h80007FFF, 64'h0, 0, 0, 1, 0, "R4 diff only");
    bigStep(64'h00007FFF, 64'h00007FFF, 64'h7FFFFFFF, 0, 1, 1, 0, "R3 pos overflow");
    check("R5 set", longint'(bFlag), 1);
    bigStep(64'h0, 64'h0, 64'h0, 0, 1, 1, 0, "R5 sticky");
    bigStep(64'h7FFF0000, 64'h7FFF0000, 64'h80000000, 0, 1, 1, 1, "R6 clear loses");
    check("R6 overflow wins", longint'(bFlag), 1);
    bigStep(64'h1, 64'h1, 64'h0, 0, 1, 0, 1, "R6 clear no en");
    check("R6 cleared", longint'(bFlag), 0);
    bigStep(64'h00007FFF, 64'h00007FFF, 64'h7FFFFFFF, 0, 1, 0, 0, "R7 hold");
    check("R7 flag held low", longint'(bFlag), 0);
    bigStep(64'h80008000, 64'h80007FFF, 64'h80000000, 1, 0, 1, 0, "R4 extreme diff");
    check("R4 no flag", longint'(bFlag), 0);

    // exhaustive sweep on the small instance; every cycle checks R10 timing
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        for (int sw = 0; sw < 2; sw++)
          for (int k = 0; k < 5; k++) begin
            longint acc; bit ae; bit e; bit c; longint r; bit o; string tag;
            ae = (k != 4);
            acc = (k == 0) ? 0 : (k == 1) ? 31 : (k == 2) ? 32 : (k == 3) ? 63 : (a ^ b);
            e = (step % 7) != 3;
            c = (step % 11) == 5;
            step++;
            sA = a[5:0]; sB = b[5:0]; sAcc = acc[5:0];
            sSwap = sw[0]; sAccEn = ae; sEn = e; sClr = c;
            refCalc(SW, a, b, acc, sw[0], ae, r, o);
            if (e) sExpRes = r;
            if (e && o) sExpFlag = 1; else if (c) sExpFlag = 0;
            tag = !e ? "R7 hold" : !ae ? "R4 diff" : sw[0] ? "R2 swap" : "R3 acc";
            @(negedge clk);
            check({tag, " R1 R10 result"}, longint'(sRes), sExpRes);
            check("R5 R6 sweep flag", longint'(sFlag), longint'(sExpFlag));
          end

    // R8: reset in mid-run clears a set flag and a nonzero result
    sA = 6'h03; sB = 6'h01; sAcc = 6'h1F; sAccEn = 1; sEn = 1; sClr = 0; sSwap = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R8 mid result", longint'(sRes), 0);
    check("R8 mid flag", longint'(sFlag), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule